// File: doc/BRIEF.md
# Queued SPI Master with Per-Entry Command RAM

This block is an SPI master that sends and receives a run of up to sixteen bytes with no processor help between bytes. Software loads a transmit byte and a command word for each queue entry, writes the first and last entry numbers, and then sets one enable bit. The engine then handles each entry in turn. For every entry it drives the chip selects that the entry's command word asks for, shifts the byte out MSB first in SPI mode 0, and captures the byte that comes back on MISO into the receive RAM.

When the last entry has finished, the enable bit clears itself and a done flag is raised. The done flag also drives the interrupt output. Chip selects can stay asserted from one byte to the next, and also across separate queue runs, so a long flash transaction can be split into several runs of sixteen bytes. SCK runs at the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, `cs_no` is 4'hF, `sck_o` and `irq_o` are 0, and the control and status registers read 0.
- R2: `addr_i` is a word address (the byte offset divided by 4). The registers are: first entry 0x04, last entry 0x05, control 0x06 (bit 6 enable, bit 7 continue), status 0x08 (bit 0 done), current entry 0x09, transmit RAM 0x10–0x2F, receive RAM 0x30–0x4F, command RAM 0x50–0x5F, hold 0x60 (bit 0). Entry i uses transmit word 2i for its byte, bits [7:0]. The odd transmit words and the even receive words always read 0.
- R3: While an entry runs, `cs_no` equals bits [3:0] of that entry's command word. A 0 bit drives its line low, and 0xF selects no line.
- R4: If command bit 7 of an entry is clear, `cs_no` returns to 4'hF on the clock after that entry's last SCK fall. If the bit is set, the lines stay as they are until the next entry loads its own value.
- R5: SPI mode 0, MSB first. SCK idles low and each SCK phase lasts CLK_DIV/2 clocks. The first rising edge comes CLK_DIV/2 clocks after the entry loads. MOSI changes only on a falling edge or when an entry loads.
- R6: Command bit 4 adds exactly one extra clock before an entry's first SCK rise.
- R7: MISO is sampled on each SCK rise. The 8-bit result of entry i reads back from receive word 2i+1.
- R8: Entries run in order from the first pointer to the last pointer, inclusive, wrapping from 15 to 0. After a run, the current-entry register reads the last entry.
- R9: Writing control with bit 6 set while idle starts a run. Bit 6 reads 1 while the run is busy and clears by itself when the last entry finishes.
- R10: The done flag sets when a run finishes, and `irq_o` follows it. Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged.
- R11: While control bit 7 is set, the chip selects stay asserted after a run ends. They are released on the clock after software clears that bit.
- R12: While the hold register bit 0 is 1, the chip selects stay asserted after a run ends. They are released on the clock after it is written to 0, provided bit 7 of control is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |
| irq_o | output | 1 | Done interrupt |

## Verification
Several rules are checked by assertions on every clock:
- SCK stays low whenever the engine is idle.
- The chip selects and MOSI do not move at an SCK rise or while SCK is high.
- The enable bit is already clear when the interrupt rises.
- Released chip selects follow idle whenever neither hold source is set.

The rest needs the bench's scenarios and its cycle-exact reference timeline:
- the exact clock of every SCK edge, including the extra delay clock;
- the chip-select release rules between bytes and at the end of a run;
- pointer wrap;
- the round trip of bytes through the transmit and receive slots, checked against a serial slave model.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned PTR_W   = $clog2(ENTRIES);
  localparam int unsigned SLOTS   = 2 * ENTRIES;

  // word addresses
  localparam logic [7:0] A_FIRST = 8'h04;
  localparam logic [7:0] A_LAST  = 8'h05;
  localparam logic [7:0] A_CTRL  = 8'h06;
  localparam logic [7:0] A_STAT  = 8'h08;
  localparam logic [7:0] A_CUR   = 8'h09;
  localparam logic [7:0] A_TX    = 8'h10;
  localparam logic [7:0] A_RX    = 8'h30;
  localparam logic [7:0] A_CMD   = 8'h50;
  localparam logic [7:0] A_HOLD  = 8'h60;

  localparam int unsigned CTRL_RUN  = 6;
  localparam int unsigned CTRL_CONT = 7;
  localparam int unsigned CMD_DLY   = 4;
  localparam int unsigned CMD_KEEP  = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_DELAY, SH_LOW, SH_HIGH} sh_state_e;
endpackage

// File: rtl/qsm_regs.sv
module qsm_regs
  import qsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [PTR_W-1:0] cur_ptr_i,
  input  logic             rx_we_i,
  input  logic [7:0]       rx_data_i,
  input  logic             finish_i,
  output logic             start_o,
  output logic [PTR_W-1:0] first_ptr_o,
  output logic [PTR_W-1:0] last_ptr_o,
  output logic             run_o,
  output logic             cont_o,
  output logic             hold_o,
  output logic             done_o,
  output logic [3:0]       ent_cs_o,
  output logic             ent_dly_o,
  output logic             ent_keep_o,
  output logic [7:0]       ent_tx_o
);

  logic wr;
  logic [7:0] tx_off, rx_off, cmd_off;
  logic tx_hit, rx_hit, cmd_hit;
  logic [PTR_W-1:0] tx_ent, rx_ent, cmd_ent;
  logic [7:0] tx_arr  [ENTRIES];
  logic [7:0] rx_arr  [ENTRIES];
  logic [7:0] cmd_arr [ENTRIES];
  logic [PTR_W-1:0] first_q, last_q;
  logic run_q, cont_q, done_q, hold_q;
  logic unused_bits;

  assign wr      = req_i & we_i;
  assign tx_off  = addr_i - A_TX;
  assign rx_off  = addr_i - A_RX;
  assign cmd_off = addr_i - A_CMD;
  assign tx_hit  = (addr_i >= A_TX)  && (addr_i < A_TX + 8'(SLOTS));
  assign rx_hit  = (addr_i >= A_RX)  && (addr_i < A_RX + 8'(SLOTS));
  assign cmd_hit = (addr_i >= A_CMD) && (addr_i < A_CMD + 8'(ENTRIES));
  assign tx_ent  = tx_off[PTR_W:1];
  assign rx_ent  = rx_off[PTR_W:1];
  assign cmd_ent = cmd_off[PTR_W-1:0];

  assign unused_bits = ^{wdata_i[31:8], tx_off[7:PTR_W+1], rx_off[7:PTR_W+1], cmd_off[7:PTR_W]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [7:0] tx_q, cmd_q, rx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q  <= '0;
        cmd_q <= '0;
        rx_q  <= '0;
      end else begin
        if (wr && tx_hit && !tx_off[0] && tx_ent == PTR_W'(e)) tx_q <= wdata_i[7:0];
        if (wr && cmd_hit && cmd_ent == PTR_W'(e))             cmd_q <= wdata_i[7:0];
        if (rx_we_i && cur_ptr_i == PTR_W'(e))                 rx_q <= rx_data_i;
      end
    end
    assign tx_arr[e]  = tx_q;
    assign cmd_arr[e] = cmd_q;
    assign rx_arr[e]  = rx_q;
  end

  assign start_o = wr && (addr_i == A_CTRL) && wdata_i[CTRL_RUN] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      run_q   <= 1'b0;
      cont_q  <= 1'b0;
      done_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (wr && addr_i == A_FIRST) first_q <= wdata_i[PTR_W-1:0];
      if (wr && addr_i == A_LAST)  last_q  <= wdata_i[PTR_W-1:0];
      if (wr && addr_i == A_CTRL)  cont_q  <= wdata_i[CTRL_CONT];
      if (wr && addr_i == A_HOLD)  hold_q  <= wdata_i[0];
      if (start_o)       run_q <= 1'b1;
      else if (finish_i) run_q <= 1'b0;
      if (finish_i)                                 done_q <= 1'b1;
      else if (wr && addr_i == A_STAT && !wdata_i[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (tx_hit) begin
      if (!tx_off[0]) rdata_o[7:0] = tx_arr[tx_ent];
    end else if (rx_hit) begin
      if (rx_off[0]) rdata_o[7:0] = rx_arr[rx_ent];
    end else if (cmd_hit) begin
      rdata_o[7:0] = cmd_arr[cmd_ent];
    end else begin
      case (addr_i)
        A_FIRST: rdata_o[PTR_W-1:0] = first_q;
        A_LAST:  rdata_o[PTR_W-1:0] = last_q;
        A_CTRL: begin
          rdata_o[CTRL_RUN]  = run_q;
          rdata_o[CTRL_CONT] = cont_q;
        end
        A_STAT:  rdata_o[0] = done_q;
        A_CUR:   rdata_o[PTR_W-1:0] = cur_ptr_i;
        A_HOLD:  rdata_o[0] = hold_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign first_ptr_o = first_q;
  assign last_ptr_o  = last_q;
  assign run_o       = run_q;
  assign cont_o      = cont_q;
  assign hold_o      = hold_q;
  assign done_o      = done_q;
  assign ent_cs_o    = cmd_arr[cur_ptr_i][3:0];
  assign ent_dly_o   = cmd_arr[cur_ptr_i][CMD_DLY];
  assign ent_keep_o  = cmd_arr[cur_ptr_i][CMD_KEEP];
  assign ent_tx_o    = tx_arr[cur_ptr_i];

endmodule

// File: rtl/qsm_seq.sv
module qsm_seq
  import qsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PTR_W-1:0] first_ptr_i,
  input  logic [PTR_W-1:0] last_ptr_i,
  input  logic [3:0]       ent_cs_i,
  input  logic             ent_keep_i,
  input  logic             cont_i,
  input  logic             hold_i,
  input  logic             byte_done_i,
  output logic             load_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             rx_we_o,
  output logic             finish_o,
  output logic [3:0]       cs_no
);

  seq_state_e state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [3:0] cs_q;
  logic at_last;

  assign at_last  = (ptr_q == last_ptr_i);
  assign load_o   = (state_q == SQ_SETUP);
  assign rx_we_o  = (state_q == SQ_WAIT) && byte_done_i;
  assign finish_o = rx_we_o && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      cs_q    <= 4'hF;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            ptr_q   <= first_ptr_i;
            state_q <= SQ_SETUP;
          end else if (!hold_i && !cont_i) begin
            cs_q <= 4'hF;
          end
        end
        SQ_SETUP: begin
          cs_q    <= ent_cs_i;
          state_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (byte_done_i) begin
            // last entry keeps select when a run-spanning hold is active
            if (!ent_keep_i && !(at_last && (cont_i || hold_i))) cs_q <= 4'hF;
            if (at_last) begin
              state_q <= SQ_IDLE;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= SQ_SETUP;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign ptr_o = ptr_q;
  assign cs_no = cs_q;

endmodule

// File: rtl/qsm_shift.sv
module qsm_shift
  import qsm_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] tx_i,
  input  logic       dly_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);

  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  sh_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] txsh_q, rxsh_q;
  logic sck_q, done_q;
  logic half_end;

  assign half_end = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SH_IDLE: begin
          if (load_i) begin
            txsh_q  <= tx_i;
            bit_q   <= '0;
            cnt_q   <= '0;
            state_q <= dly_i ? SH_DELAY : SH_LOW;
          end
        end
        SH_DELAY: begin
          cnt_q   <= '0;
          state_q <= SH_LOW;
        end
        SH_LOW: begin
          if (half_end) begin
            cnt_q   <= '0;
            sck_q   <= 1'b1;
            rxsh_q  <= {rxsh_q[6:0], miso_i};
            state_q <= SH_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SH_HIGH: begin
          if (half_end) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              done_q  <= 1'b1;
              state_q <= SH_IDLE;
            end else begin
              bit_q   <= bit_q + 1'b1;
              txsh_q  <= {txsh_q[6:0], 1'b0};
              state_q <= SH_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = txsh_q[7];
  assign rx_o   = rxsh_q;
  assign done_o = done_q;

endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import qsm_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [3:0]  cs_no,
  output logic        irq_o
);

  logic start, spe, cont_after, wlock, done, finish, load, rx_we, byte_done;
  logic ent_dly, ent_keep;
  logic [3:0] ent_cs;
  logic [7:0] ent_tx, rx_byte;
  logic [PTR_W-1:0] ptr, first_ptr, last_ptr;

  qsm_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .cur_ptr_i   (ptr),
    .rx_we_i     (rx_we),
    .rx_data_i   (rx_byte),
    .finish_i    (finish),
    .start_o     (start),
    .first_ptr_o (first_ptr),
    .last_ptr_o  (last_ptr),
    .run_o       (spe),
    .cont_o      (cont_after),
    .hold_o      (wlock),
    .done_o      (done),
    .ent_cs_o    (ent_cs),
    .ent_dly_o   (ent_dly),
    .ent_keep_o  (ent_keep),
    .ent_tx_o    (ent_tx)
  );

  qsm_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .first_ptr_i (first_ptr),
    .last_ptr_i  (last_ptr),
    .ent_cs_i    (ent_cs),
    .ent_keep_i  (ent_keep),
    .cont_i      (cont_after),
    .hold_i      (wlock),
    .byte_done_i (byte_done),
    .load_o      (load),
    .ptr_o       (ptr),
    .rx_we_o     (rx_we),
    .finish_o    (finish),
    .cs_no       (cs_no)
  );

  qsm_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .tx_i   (ent_tx),
    .dly_i  (ent_dly),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_byte),
    .done_o (byte_done)
  );

  assign irq_o = done;

endmodule

// File: rtl/spi_queue_master_chk.sv
module spi_queue_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_o,
  input logic       mosi_o,
  input logic [3:0] cs_no,
  input logic       irq_o,
  input logic       spe,
  input logic       wlock,
  input logic       cont_after
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spe |-> !sck_o); // R5

  AST_CS_STABLE_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(cs_no)); // R3

  AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o)); // R5

  AST_RUN_CLEAR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !spe); // R9

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spe && !wlock && !cont_after && $past(!spe && !wlock && !cont_after))
      |-> cs_no == 4'hF); // R12

endmodule

bind spi_queue_master spi_queue_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .irq_o      (irq_o),
  .spe        (spe),
  .wlock      (wlock),
  .cont_after (cont_after)
);

// File: tb/spi_queue_master_test.sv
module spi_queue_master_test;
  localparam int DIV = 4;
  localparam int H   = DIV / 2;
  localparam logic [7:0] A_FIRST = 8'h04, A_LAST = 8'h05, A_CTRL = 8'h06,
                         A_STAT = 8'h08, A_CUR = 8'h09, A_TX = 8'h10,
                         A_RX = 8'h30, A_CMD = 8'h50, A_HOLD = 8'h60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi, miso = 1'b0, irq;
  logic [3:0] cs_n;

  int checks = 0, errors = 0;
  bit cmp_en = 0, mosi_chk = 0;
  logic exp_sck = 1'b0, exp_mosi = 1'b0, exp_irq = 1'b0;
  logic [3:0] exp_cs = 4'hF;
  bit m_hold = 0;

  logic [7:0] m_tx [16];
  logic [7:0] m_cmd [16];
  logic [7:0] rep [16];
  logic [7:0] got [16];
  int ngot = 0, sidx = 0, sbits = 0;
  logic [7:0] sin = '0, cur = '0;

  always #4 clk = ~clk;

  spi_queue_master #(.CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference timeline
  always @(negedge clk) if (cmp_en) begin
    chk(sck === exp_sck, "R5 sck", 32'(sck), 32'(exp_sck));
    chk(cs_n === exp_cs, "R3/R4 cs", 32'(cs_n), 32'(exp_cs));
    chk(irq === exp_irq, "R10 irq", 32'(irq), 32'(exp_irq));
    if (mosi_chk) chk(mosi === exp_mosi, "R5 mosi", 32'(mosi), 32'(exp_mosi));
  end

  // mode-0 slave model
  always @(posedge sck) begin
    sin = {sin[6:0], mosi};
    sbits++;
    if (sbits == 8) begin
      if (ngot < 16) got[ngot] = sin;
      ngot++;
      sbits = 0;
    end
  end
  always @(negedge sck) begin
    if (sbits == 0) begin
      sidx++;
      cur  = (sidx < 16) ? rep[sidx] : 8'h00;
      miso = cur[7];
    end else begin
      miso = cur[7 - sbits];
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic load_entry(input int e, input logic [7:0] tx, input logic [7:0] cmd);
    m_tx[e] = tx; m_cmd[e] = cmd;
    bus_wr(A_TX + 8'(2 * e), {24'h0, tx});
    bus_wr(A_CMD + 8'(e), {24'h0, cmd});
  endtask

  task automatic run_queue(input int first, input int last, input bit cont_after);
    int e, k;
    bit lastf;
    logic [31:0] d;
    bus_wr(A_FIRST, first);
    bus_wr(A_LAST, last);
    sidx = 0; sbits = 0; ngot = 0; cur = rep[0]; miso = rep[0][7];
    bus_wr(A_CTRL, {24'h0, cont_after, 1'b1, 6'h0});
    e = first; k = 0;
    forever begin
      @(posedge clk);                       // entry load
      exp_cs = m_cmd[e][3:0];
      if (m_cmd[e][4]) @(posedge clk);      // R6 extra clock
      for (int b = 7; b >= 0; b--) begin
        repeat (H) @(posedge clk);
        exp_sck = 1'b1; exp_mosi = m_tx[e][b]; mosi_chk = 1;
        repeat (H) @(posedge clk);
        exp_sck = 1'b0; mosi_chk = 0;
      end
      @(posedge clk);                       // byte wrap-up
      lastf = (e == last);
      if (!m_cmd[e][7] && !(lastf && (cont_after || m_hold))) exp_cs = 4'hF;
      if (lastf) begin
        exp_irq = 1'b1;
        break;
      end
      e = (e + 1) % 16;
      k++;
    end
    @(posedge clk);
    if (!m_hold && !cont_after) exp_cs = 4'hF;
    repeat (2) @(posedge clk);
    chk(ngot == k + 1, "R8 byte count", 32'(ngot), 32'(k + 1));
    for (int kk = 0; kk <= k; kk++) begin
      int ee;
      ee = (first + kk) % 16;
      chk(got[kk] == m_tx[ee], "R5 shifted byte", 32'(got[kk]), 32'(m_tx[ee]));
      bus_rd(A_RX + 8'(2 * ee + 1), d);
      chk(d == 32'(rep[kk]), "R7 rx slot", d, 32'(rep[kk]));
      bus_rd(A_RX + 8'(2 * ee), d);
      chk(d == 32'h0, "R2 rx even slot", d, 32'h0);
    end
    bus_rd(A_CTRL, d);
    chk(d[6] == 1'b0, "R9 enable self-clear", 32'(d[6]), 32'h0);
    bus_rd(A_STAT, d);
    chk(d == 32'h1, "R10 done flag", d, 32'h1);
    bus_rd(A_CUR, d);
    chk(d == 32'(last), "R8 current entry", d, 32'(last));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_en = 1;
    // R1
    bus_rd(A_CTRL, d); chk(d == 0, "R1 control reset", d, 0);
    bus_rd(A_STAT, d); chk(d == 0, "R1 status reset", d, 0);
    chk(cs_n == 4'hF && sck == 0 && irq == 0, "R1 pins reset", {cs_n, sck, irq}, 32'h3C);
    // R2
    bus_wr(A_TX + 8'd6, 32'h5A); bus_rd(A_TX + 8'd6, d);
    chk(d == 32'h5A, "R2 tx readback", d, 32'h5A);
    bus_wr(A_TX + 8'd7, 32'h77); bus_rd(A_TX + 8'd7, d);
    chk(d == 0, "R2 tx odd slot", d, 0);
    bus_wr(A_CMD + 8'd9, 32'h9D); bus_rd(A_CMD + 8'd9, d);
    chk(d == 32'h9D, "R2 cmd readback", d, 32'h9D);

    // S1: four bytes on line 0, select kept between bytes (R3 R4 R5 R7 R8)
    load_entry(0, 8'hA5, 8'h8E); load_entry(1, 8'h3C, 8'h8E);
    load_entry(2, 8'hF0, 8'h8E); load_entry(3, 8'h81, 8'h0E);
    rep[0] = 8'h11; rep[1] = 8'h22; rep[2] = 8'hC3; rep[3] = 8'h7E;
    run_queue(0, 3, 0);
    bus_wr(A_STAT, 32'h1); bus_rd(A_STAT, d);
    chk(d == 32'h1, "R10 write 1 keeps flag", d, 1);
    bus_wr(A_STAT, 32'h0); exp_irq = 1'b0; bus_rd(A_STAT, d);
    chk(d == 0, "R10 write 0 clears", d, 0);

    // S2: delay clock and release between bytes (R4 R6)
    load_entry(5, 8'h96, 8'h1D); load_entry(6, 8'h01, 8'h17);
    rep[0] = 8'hE7; rep[1] = 8'h5B;
    run_queue(5, 6, 0);
    bus_wr(A_STAT, 32'h0); exp_irq = 1'b0;

    // S3: wrap 15->0 with hold register set (R8 R12)
    bus_wr(A_HOLD, 32'h1); m_hold = 1;
    load_entry(15, 8'h4D, 8'h8B); load_entry(0, 8'hB2, 8'h0B);
    rep[0] = 8'h69; rep[1] = 8'h0F;
    run_queue(15, 0, 0);
    chk(cs_n == 4'hB, "R12 held after run", 32'(cs_n), 32'hB);
    bus_wr(A_HOLD, 32'h0); m_hold = 0;
    @(posedge clk); exp_cs = 4'hF;
    @(negedge clk);
    chk(cs_n == 4'hF, "R12 released after hold clear", 32'(cs_n), 32'hF);
    bus_wr(A_STAT, 32'h0); exp_irq = 1'b0;

    // S4: continue-after bit keeps select (R11)
    load_entry(2, 8'h3A, 8'h07);
    rep[0] = 8'hD4;
    run_queue(2, 2, 1);
    chk(cs_n == 4'h7, "R11 held after run", 32'(cs_n), 32'h7);
    bus_wr(A_CTRL, 32'h0);
    @(posedge clk); exp_cs = 4'hF;
    @(negedge clk);
    chk(cs_n == 4'hF, "R11 released after clear", 32'(cs_n), 32'hF);
    bus_wr(A_STAT, 32'h0); exp_irq = 1'b0;

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule